// File: doc/BRIEF.md
# Next-Program-Counter Unit for Branch, Jump and Skip Control Flow

This block decides where a small word-addressed RISC core fetches next and how many cycles the current instruction occupies. Each cycle in which `in_valid` is high, it receives the current program counter and a decoded control-flow class. It also receives the operands that class needs: a signed displacement, a 16-bit indirect pointer, the processor status byte, a tested register or I/O bit, a compare-equal result, and the lengths of the current and following instructions. One clock later it presents the next program counter and the cycle count.

The classes cover plain sequential flow, relative jumps, indirect jumps, branches on any status bit being set or clear, the signed greater-or-equal and less-than branches, and three skip forms. A skip that fires jumps over the following instruction, so its distance and cost depend on whether that instruction is one or two words long. All program-counter arithmetic wraps within `PC_W` bits.

Top module: `npc_unit`

## Requirements
- R1: While reset is applied, `out_valid`, `next_pc` and `cycles` are all zero.
- R2: Class 0 (sequential), and every unused class code from 10 to 15, gives `pc + 1`, or `pc + 2` when `cur_two_word` is 1, with a cycle count of 1.
- R3: Class 1 (relative jump) gives `pc + sext(disp[11:0]) + 1` modulo 2^PC_W, with a cycle count of 2.
- R4: Class 2 (indirect jump) gives the low `PC_W` bits of `z_ptr`, with a cycle count of 2.
- R5: Class 3 is taken when `status[bit_sel]` is 1, and class 4 when it is 0. The status byte layout is: bit 0 carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half carry, 6 transfer bit, 7 interrupt enable.
- R6: Class 5 (signed greater-or-equal) is taken when status bit 2 XOR status bit 3 is 0. Class 6 (signed less-than) is taken when that XOR is 1.
- R7: A taken branch (classes 3 to 6) gives `pc + sext(disp[6:0]) + 1` with 2 cycles. A branch that is not taken gives `pc + 1` with 1 cycle. `disp[11:7]` has no effect on either result.
- R8: The skip condition holds for class 7 when `test_bit` is 0, for class 8 when `test_bit` is 1, and for class 9 when `cmp_eq` is 1. When it holds, the result is `pc + 2` with 2 cycles, or `pc + 3` with 3 cycles when `next_two_word` is 1.
- R9: A skip whose condition fails gives `pc + 1` with 1 cycle, whatever `next_two_word` is.
- R10: A request with `in_valid` high at one rising edge appears at the next edge with `out_valid` high for that cycle. With `in_valid` low, `out_valid` is 0 and `next_pc` and `cycles` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe |
| pc | input | PC_W | Current program counter (words) |
| op | input | 4 | Control-flow class code |
| bit_sel | input | 3 | Status bit index for classes 3 and 4 |
| disp | input | 12 | Signed displacement; the low 7 bits are used for branches |
| z_ptr | input | 16 | Indirect jump target |
| status | input | 8 | Processor status byte |
| test_bit | input | 1 | Register or I/O bit under test |
| cmp_eq | input | 1 | Result of the equality comparison for class 9 |
| cur_two_word | input | 1 | Current instruction is two words long |
| next_two_word | input | 1 | Following instruction is two words long |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Next program counter |
| cycles | output | 2 | Cycle count of the instruction |

## Verification
Every branch class and every status bit index is swept over all 256 status-byte values. This separates a wrong bit index, a swapped set/clear sense, and a GE/LT condition taken from the wrong flag pair. Displacements vary from sweep to sweep and carry junk in bits 11:7, which exposes a branch that reads the wide field or sign-extends from the wrong bit. Directed cases apply the skip forms with both following-instruction lengths and both condition outcomes. Further cases push the relative jumps and branches across the address wrap in both directions, and a final idle stretch changes the inputs with the strobe low to show the outputs hold.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    CF_SEQ    = 4'd0,
    CF_RJMP   = 4'd1,
    CF_IJMP   = 4'd2,
    CF_BSET   = 4'd3,
    CF_BCLR   = 4'd4,
    CF_BGE    = 4'd5,
    CF_BLT    = 4'd6,
    CF_SKCLR  = 4'd7,
    CF_SKSET  = 4'd8,
    CF_SKEQ   = 4'd9
  } cf_op_e;

  localparam int FLAG_NEG = 2;
  localparam int FLAG_OVF = 3;

  function automatic logic is_branch(input logic [3:0] op);
    return (op == CF_BSET) || (op == CF_BCLR) || (op == CF_BGE) || (op == CF_BLT);
  endfunction

  function automatic logic is_skip(input logic [3:0] op);
    return (op == CF_SKCLR) || (op == CF_SKSET) || (op == CF_SKEQ);
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [3:0] op,
  input  logic [2:0] bit_sel,
  input  logic [7:0] status,
  input  logic       test_bit,
  input  logic       cmp_eq,
  output logic       cond_hold
);
  logic sel_flag;
  logic sign_lt;

  assign sel_flag = status[bit_sel];
  assign sign_lt  = status[FLAG_NEG] ^ status[FLAG_OVF];

  always_comb begin
    unique case (op)
      CF_BSET:  cond_hold = sel_flag;
      CF_BCLR:  cond_hold = ~sel_flag;
      CF_BGE:   cond_hold = ~sign_lt;
      CF_BLT:   cond_hold = sign_lt;
      CF_SKCLR: cond_hold = ~test_bit;
      CF_SKSET: cond_hold = test_bit;
      CF_SKEQ:  cond_hold = cmp_eq;
      default:  cond_hold = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0] pc,
  input  logic [3:0]      op,
  input  logic [11:0]     disp,
  input  logic [15:0]     z_ptr,
  input  logic            cond_hold,
  input  logic            cur_two_word,
  input  logic            next_two_word,
  output logic [PC_W-1:0] npc,
  output logic [1:0]      cyc
);
  localparam int BR_W = 7;

  logic [PC_W-1:0] off_long;
  logic [PC_W-1:0] off_short;
  logic [PC_W-1:0] pc_inc1;
  logic [PC_W-1:0] skip_dist;

  assign off_long  = PC_W'($signed(disp));
  assign off_short = PC_W'($signed(disp[BR_W-1:0]));
  assign pc_inc1   = pc + PC_W'(1);
  assign skip_dist = next_two_word ? PC_W'(3) : PC_W'(2);

  always_comb begin
    npc = pc_inc1;
    cyc = 2'd1;
    if (op == CF_RJMP) begin
      npc = pc_inc1 + off_long;
      cyc = 2'd2;
    end else if (op == CF_IJMP) begin
      npc = z_ptr[PC_W-1:0];
      cyc = 2'd2;
    end else if (is_branch(op)) begin
      if (cond_hold) begin
        npc = pc_inc1 + off_short;
        cyc = 2'd2;
      end
    end else if (is_skip(op)) begin
      if (cond_hold) begin
        npc = pc + skip_dist;
        cyc = next_two_word ? 2'd3 : 2'd2;
      end
    end else begin
      npc = cur_two_word ? pc + PC_W'(2) : pc_inc1;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] pc,
  input  logic [3:0]      op,
  input  logic [2:0]      bit_sel,
  input  logic [11:0]     disp,
  input  logic [15:0]     z_ptr,
  input  logic [7:0]      status,
  input  logic            test_bit,
  input  logic            cmp_eq,
  input  logic            cur_two_word,
  input  logic            next_two_word,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic [1:0]      cycles
);
  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic            cond_hold;
  logic [PC_W-1:0] npc_d;
  logic [1:0]      cyc_d;

  // reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  npc_cond u_cond (
    .op        (op),
    .bit_sel   (bit_sel),
    .status    (status),
    .test_bit  (test_bit),
    .cmp_eq    (cmp_eq),
    .cond_hold (cond_hold)
  );

  npc_target #(.PC_W(PC_W)) u_target (
    .pc            (pc),
    .op            (op),
    .disp          (disp),
    .z_ptr         (z_ptr),
    .cond_hold     (cond_hold),
    .cur_two_word  (cur_two_word),
    .next_two_word (next_two_word),
    .npc           (npc_d),
    .cyc           (cyc_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      next_pc <= '0;
      cycles  <= 2'd0;
    end else if (in_valid) begin
      next_pc <= npc_d;
      cycles  <= cyc_d;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_q,
  input logic            in_valid,
  input logic [PC_W-1:0] pc,
  input logic [3:0]      op,
  input logic [15:0]     z_ptr,
  input logic            cmp_eq,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic [1:0]      cycles
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(cycles)));

  // R2
  seq_cost_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op == 4'd0) |=> (cycles == 2'd1));

  // R4
  ijmp_target_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op == 4'd2) |=> (next_pc == $past(z_ptr[PC_W-1:0]) && cycles == 2'd2));

  // R9
  skip_fail_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op == 4'd9 && !cmp_eq) |=>
      (cycles == 2'd1 && next_pc == PC_W'($past(pc) + PC_W'(1))));

  // R8
  cost_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (cycles != 2'd0));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .in_valid  (in_valid),
  .pc        (pc),
  .op        (op),
  .z_ptr     (z_ptr),
  .cmp_eq    (cmp_eq),
  .out_valid (out_valid),
  .next_pc   (next_pc),
  .cycles    (cycles)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam int PC_W = 12;
  localparam int MASK = (1 << PC_W) - 1;

  typedef struct {
    int    epc;
    int    ecyc;
    string tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [PC_W-1:0] pc;
  logic [3:0]      op;
  logic [2:0]      bit_sel;
  logic [11:0]     disp;
  logic [15:0]     z_ptr;
  logic [7:0]      status;
  logic            test_bit, cmp_eq, cur_two_word, next_two_word;
  logic            out_valid;
  logic [PC_W-1:0] next_pc;
  logic [1:0]      cycles;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  npc_unit #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .op(op),
    .bit_sel(bit_sel), .disp(disp), .z_ptr(z_ptr), .status(status),
    .test_bit(test_bit), .cmp_eq(cmp_eq), .cur_two_word(cur_two_word),
    .next_two_word(next_two_word), .out_valid(out_valid),
    .next_pc(next_pc), .cycles(cycles)
  );

  function automatic void model(input int o, input int s, input int d, input int z,
                                input int st, input int tb, input int eq, input int c2,
                                input int n2, input int p, output int epc, output int ecyc);
    int d12, d7;
    bit hold;
    d12 = (d & 12'h800) ? (d & 12'hFFF) - 4096 : (d & 12'hFFF);
    d7  = (d & 7'h40) ? (d & 7'h7F) - 128 : (d & 7'h7F);
    hold = 0;
    case (o)
      1: begin epc = p + d12 + 1; ecyc = 2; end
      2: begin epc = z; ecyc = 2; end
      3, 4, 5, 6: begin
        if (o == 3) hold = ((st >> s) & 1) == 1;
        if (o == 4) hold = ((st >> s) & 1) == 0;
        if (o == 5) hold = (((st >> 2) ^ (st >> 3)) & 1) == 0;
        if (o == 6) hold = (((st >> 2) ^ (st >> 3)) & 1) == 1;
        if (hold) begin epc = p + d7 + 1; ecyc = 2; end
        else      begin epc = p + 1;      ecyc = 1; end
      end
      7, 8, 9: begin
        if (o == 7) hold = (tb == 0);
        if (o == 8) hold = (tb == 1);
        if (o == 9) hold = (eq == 1);
        if (hold) begin epc = p + (n2 ? 3 : 2); ecyc = n2 ? 3 : 2; end
        else      begin epc = p + 1;            ecyc = 1; end
      end
      default: begin epc = p + (c2 ? 2 : 1); ecyc = 1; end
    endcase
    epc = epc & MASK;
  endfunction

  task automatic send(input int o, input int s, input int d, input int z, input int st,
                      input int tb, input int eq, input int c2, input int n2,
                      input int p, input string tag);
    exp_t e;
    model(o, s, d, z, st, tb, eq, c2, n2, p, e.epc, e.ecyc);
    e.tag = tag;
    in_valid = 1'b1;
    op = 4'(o); bit_sel = 3'(s); disp = 12'(d); z_ptr = 16'(z); status = 8'(st);
    test_bit = 1'(tb); cmp_eq = 1'(eq); cur_two_word = 1'(c2);
    next_two_word = 1'(n2); pc = PC_W'(p);
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected result next_pc=%0d cycles=%0d expected no result",
                 next_pc, cycles);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (int'(next_pc) != e.epc || int'(cycles) != e.ecyc) begin
          errors++;
          $display("FAIL %s: next_pc=%0d cycles=%0d expected next_pc=%0d cycles=%0d",
                   e.tag, next_pc, cycles, e.epc, e.ecyc);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      $display("FAIL watchdog: cycle=%0d expected completion", cyc_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] held_pc;
    logic [1:0]      held_cyc;
    rst_n = 1'b0; in_valid = 1'b0; pc = '0; op = '0; bit_sel = '0; disp = '0;
    z_ptr = '0; status = '0; test_bit = 1'b0; cmp_eq = 1'b0;
    cur_two_word = 1'b0; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || next_pc !== '0 || cycles !== 2'd0) begin
      errors++;
      $display("FAIL R1: out_valid=%0b next_pc=%0d cycles=%0d expected 0 0 0",
               out_valid, next_pc, cycles);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 sequential and unused codes, with wrap
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 100, "R2");
    send(0, 0, 0, 0, 0, 0, 0, 1, 0, 100, "R2");
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, MASK, "R2");
    send(0, 0, 0, 0, 0, 0, 0, 1, 0, MASK, "R2");
    for (int o = 10; o < 16; o++) send(o, 1, 12'h7FF, 9, 8'hFF, 1, 1, o & 1, 1, 50 + o, "R2");
    // R3 relative jumps
    send(1, 0, 12'h000, 0, 0, 0, 0, 0, 0, 20, "R3");
    send(1, 0, 12'h7FF, 0, 0, 0, 0, 0, 0, 20, "R3");
    send(1, 0, 12'h800, 0, 0, 0, 0, 0, 0, 5, "R3");
    send(1, 0, 12'hFFF, 0, 0, 0, 0, 0, 0, 0, "R3");
    send(1, 0, 12'h7FF, 0, 0, 0, 0, 0, 0, 3000, "R3");
    // R4 indirect jumps
    send(2, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 7, "R4");
    send(2, 0, 0, 16'h1234, 0, 0, 0, 0, 0, 7, "R4");
    // R7 branch wrap and ignored upper displacement bits
    send(3, 0, 12'hF40, 0, 8'h01, 0, 0, 0, 0, 10, "R7");
    send(3, 0, 12'hF3F, 0, 8'h01, 0, 0, 0, 0, MASK - 2, "R7");
    send(4, 0, 12'hF80, 0, 8'h01, 0, 0, 0, 0, 10, "R7");
    // R8 / R9 skips
    for (int k = 0; k < 8; k++) begin
      send(7, 0, 0, 0, 0, k & 1, 0, 0, (k >> 1) & 1, 200 + k, ((k & 1) == 0) ? "R8" : "R9");
      send(8, 0, 0, 0, 0, k & 1, 0, 0, (k >> 1) & 1, 300 + k, ((k & 1) == 1) ? "R8" : "R9");
      send(9, 0, 0, 0, 0, 0, k & 1, 0, (k >> 1) & 1, MASK - (k & 3), ((k & 1) == 1) ? "R8" : "R9");
    end
    // R5 / R6 / R7 full status sweep
    for (int sr = 0; sr < 256; sr++) begin
      for (int s = 0; s < 8; s++) begin
        send(3, s, (sr * 37 + s * 11) & 12'hFFF, 0, sr, 0, 0, 0, 0, (sr * 53 + s * 7) & MASK, "R5");
        send(4, s, (sr * 29 + s * 13) & 12'hFFF, 0, sr, 0, 0, 0, 0, (sr * 17 + s * 3) & MASK, "R5");
      end
      send(5, 0, (sr * 19) & 12'hFFF, 0, sr, 0, 0, 0, 0, (sr * 41) & MASK, "R6");
      send(6, 0, (sr * 23) & 12'hFFF, 0, sr, 0, 0, 0, 0, (sr * 43) & MASK, "R6");
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R10 outputs hold while the strobe is low
    held_pc  = next_pc;
    held_cyc = cycles;
    op = 4'd1; disp = 12'h123; pc = PC_W'(999); z_ptr = 16'hABCD; status = 8'hFF;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || next_pc !== held_pc || cycles !== held_cyc) begin
      errors++;
      $display("FAIL R10: out_valid=%0b next_pc=%0d cycles=%0d expected 0 %0d %0d",
               out_valid, next_pc, cycles, held_pc, held_cyc);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d results missing expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule